// File: doc/BRIEF.md
# Opcode Field Decoder for an 8-bit Accumulator CPU

This block classifies one opcode byte of an 8-bit accumulator-style CPU. It does not use a flat lookup. It splits the byte into three fields: a 3-bit operation selector `aaa` in bits 7:5, a 3-bit mode selector `bbb` in bits 4:2, and a 2-bit group selector `cc` in bits 1:0. From these fields it derives:

- the instruction group,
- the operation number within that group,
- an addressing-mode code,
- a legal flag,
- a flag that marks an undefined slot which still fetches an operand.

It also flags conditional branches, and gives their condition flag and required value. It flags the single-bit set/clear form and the single-bit test-and-branch form, and gives the bit number and polarity of each.

A fetch or issue stage would place this block just after the opcode byte is captured. The outputs can be combinational. They can also pass through one output register, chosen by the `REG_OUT` parameter (default 1). When the register is present it has an active-low asynchronous reset.

Top module: `opfield_decoder`

## Requirements
- R1: With `REG_OUT`=1, every output shows the decode of the opcode sampled at the previous rising clock edge. While `rst_n` is low, every output is zero.
- R2: Any opcode with bits 1:0 = 11 gives legal=0 and nop_fetch=0. Its group is 4 (extension) and op is bits 7:5. Unless R11 or R12 applies, its mode is 0 (implied).
- R3: Group code is 0 for bits 1:0 = 00, 1 for 01 and 2 for 10, except branches (R9), which use 3. For groups 0, 1, 2 and 4, op equals bits 7:5.
- R4: In group 1, bits 4:2 values 0 to 7 give modes 9 (zp,X indirect), 3 (zp), 2 (immediate), 6 (abs), 10 (zp indirect,Y), 4 (zp,X), 8 (abs,Y) and 7 (abs,X). Mode codes not named here are: 0 implied, 1 accumulator, 5 zp,Y, 11 indirect, 12 relative, 13 zp-plus-relative.
- R5: In group 1 every opcode is legal except 0x89, the store-accumulator slot with immediate mode. That slot gives legal=0, nop_fetch=1 and mode 2.
- R6: In group 2, bits 4:2 values give these modes:
  - 0: immediate (2)
  - 1: zp (3)
  - 2: accumulator (1) when bits 7:5 < 4, otherwise implied (0)
  - 3: abs (6)
  - 4: implied (0)
  - 5: zp,X (4), or zp,Y (5) when bits 7:5 are 4 or 5
  - 6: implied (0)
  - 7: abs,X (7), or abs,Y (8) when bits 7:5 are 4 or 5
- R7: In group 2, the following slots are undefined:
  - bits 4:2 = 0 with bits 7:5 other than 5: legal=0, nop_fetch=1.
  - bits 4:2 = 4: legal=0, nop_fetch=0.
  - bits 4:2 = 6 with bits 7:5 other than 4 or 5: legal=0, nop_fetch=0.

  Every other group-2 slot is legal.
- R8: Opcode 0x9E, the abs,Y slot of the store-X row, is not a store. It gives legal=0, nop_fetch=1 and mode 8.
- R9: When bits 4:0 = 10000, the opcode is a branch:
  - group 3, mode 12, legal=1
  - br_cond = bits 7:6 (0 N, 1 V, 2 C, 3 Z)
  - br_want = bit 5

  For every other opcode, br_cond and br_want are 0.
- R10: Group 0 slots follow bits 4:2, with the listed ones legal:

  | bits 4:2 | Mode | Legal when bits 7:5 are |
  |---|---|---|
  | 0 | abs (6) when bits 7:5 = 1; implied (0) for 0, 2, 3; immediate (2) for 4 to 7 | any value except 4 |
  | 1 | zp | 1, 4, 5, 6, 7 |
  | 2 | implied | any |
  | 3 | abs; indirect (11) for 0x6C | any value except 0 |
  | 5 | zp,X | 4, 5 |
  | 6 | implied | any |
  | 7 | abs,X | 5 |

  nop_fetch is always 0 in this group.
- R11: When bits 3:0 = 0111:
  - bit_op=1 and mode 3 (zp)
  - bit_idx = bits 6:4
  - bit_pol = bit 7 (1 set, 0 clear)
- R12: When bits 3:0 = 1111:
  - bit_br=1 and mode 13
  - bit_idx = bits 6:4
  - bit_pol = bit 7 (1 = branch if the bit is 1)

  Outside the R11 and R12 forms, bit_op, bit_br, bit_idx and bit_pol are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| opcode | input | 8 | Opcode byte to classify |
| grp_o | output | 3 | Instruction group code |
| op_o | output | 3 | Operation number within the group |
| mode_o | output | 4 | Addressing-mode code |
| legal_o | output | 1 | Opcode is defined by the base instruction set |
| nop_fetch_o | output | 1 | Undefined slot that still fetches an operand |
| br_cond_o | output | 2 | Flag tested by a conditional branch |
| br_want_o | output | 1 | Flag value that takes the branch |
| bit_op_o | output | 1 | Single-bit set/clear form |
| bit_br_o | output | 1 | Single-bit test-and-branch form |
| bit_idx_o | output | 3 | Bit number for the single-bit forms |
| bit_pol_o | output | 1 | Set/clear polarity or required bit value |

## Verification
The bench sweeps all 256 opcodes, once in ascending order and once in a scrambled order, and checks every field against the requirements. The sweep reaches these corner cases:

- The 0x9E slot. A decoder that treats it as a store would report it as legal and lose its operand fetch.
- The 0x89 slot. Treating it as a store would show the same two errors.
- The group-2 columns where the index register swaps from X to Y. Getting these wrong shows up as mode 4 or mode 7 where 5 or 8 is expected.
- Column 11, which must never be legal even where the single-bit forms sit.
- The 0x6C indirect jump.
- The branch column. A mis-sliced field would swap the flag or the required value.

Latency and reset are checked by holding a new opcode for part of a cycle and by pulling reset in the middle of the run.

// File: rtl/opdec_pkg.sv
`timescale 1ns/1ps
package opdec_pkg;

   typedef enum logic [2:0] {
      GRP_CTRL   = 3'd0,
      GRP_ALU    = 3'd1,
      GRP_RMW    = 3'd2,
      GRP_BRANCH = 3'd3,
      GRP_EXT    = 3'd4
   } grp_e;

   typedef enum logic [3:0] {
      AM_IMP   = 4'd0,
      AM_ACC   = 4'd1,
      AM_IMM   = 4'd2,
      AM_ZP    = 4'd3,
      AM_ZPX   = 4'd4,
      AM_ZPY   = 4'd5,
      AM_ABS   = 4'd6,
      AM_ABX   = 4'd7,
      AM_ABY   = 4'd8,
      AM_IZX   = 4'd9,
      AM_IZY   = 4'd10,
      AM_IND   = 4'd11,
      AM_REL   = 4'd12,
      AM_ZPREL = 4'd13
   } amode_e;

   typedef struct packed {
      grp_e       grp;
      logic [2:0] op;
      amode_e     mode;
      logic       legal;
      logic       nopf;
      logic [1:0] brc;
      logic       brv;
      logic       bset;
      logic       bbr;
      logic [2:0] bidx;
      logic       bpol;
   } dec_t;

   localparam int DEC_W = $bits(dec_t);

   function automatic logic mode_has_operand(input amode_e m);
      return !(m == AM_IMP || m == AM_ACC);
   endfunction

endpackage

// File: rtl/opdec_alu.sv
`timescale 1ns/1ps
module opdec_alu
   import opdec_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   localparam logic [2:0] OP_STORE = 3'd4;
   localparam logic [2:0] COL_IMM  = 3'd2;

   logic [2:0] aaa;
   logic [2:0] bbb;
   logic       undefined_slot;

   assign aaa = opc[7:5];
   assign bbb = opc[4:2];
   assign undefined_slot = (aaa == OP_STORE) && (bbb == COL_IMM);

   always_comb begin
      dec       = '0;
      dec.grp   = GRP_ALU;
      dec.op    = aaa;
      unique case (bbb)
         3'd0:    dec.mode = AM_IZX;
         3'd1:    dec.mode = AM_ZP;
         3'd2:    dec.mode = AM_IMM;
         3'd3:    dec.mode = AM_ABS;
         3'd4:    dec.mode = AM_IZY;
         3'd5:    dec.mode = AM_ZPX;
         3'd6:    dec.mode = AM_ABY;
         default: dec.mode = AM_ABX;
      endcase
      dec.legal = !undefined_slot;
      dec.nopf  = undefined_slot && mode_has_operand(dec.mode);
   end
endmodule

// File: rtl/opdec_rmw.sv
`timescale 1ns/1ps
module opdec_rmw
   import opdec_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   logic [2:0] aaa;
   logic [2:0] bbb;
   logic       xreg_row;   // store-X / load-X rows index through Y
   logic       undefined_slot;

   assign aaa      = opc[7:5];
   assign bbb      = opc[4:2];
   assign xreg_row = (aaa == 3'd4) || (aaa == 3'd5);

   always_comb begin
      undefined_slot = 1'b0;
      unique case (bbb)
         3'd0:    undefined_slot = (aaa != 3'd5);
         3'd4:    undefined_slot = 1'b1;
         3'd6:    undefined_slot = !xreg_row;
         3'd7:    undefined_slot = (aaa == 3'd4);
         default: undefined_slot = 1'b0;
      endcase
   end

   always_comb begin
      dec     = '0;
      dec.grp = GRP_RMW;
      dec.op  = aaa;
      unique case (bbb)
         3'd0:    dec.mode = AM_IMM;
         3'd1:    dec.mode = AM_ZP;
         3'd2:    dec.mode = aaa[2] ? AM_IMP : AM_ACC;
         3'd3:    dec.mode = AM_ABS;
         3'd4:    dec.mode = AM_IMP;
         3'd5:    dec.mode = xreg_row ? AM_ZPY : AM_ZPX;
         3'd6:    dec.mode = AM_IMP;
         default: dec.mode = xreg_row ? AM_ABY : AM_ABX;
      endcase
      dec.legal = !undefined_slot;
      dec.nopf  = undefined_slot && mode_has_operand(dec.mode);
   end
endmodule

// File: rtl/opdec_ctrl.sv
`timescale 1ns/1ps
module opdec_ctrl
   import opdec_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   localparam logic [4:0] BRANCH_TAIL = 5'b10000;

   logic [2:0] aaa;
   logic [2:0] bbb;
   logic       is_branch;
   logic       slot_ok;

   assign aaa       = opc[7:5];
   assign bbb       = opc[4:2];
   assign is_branch = (opc[4:0] == BRANCH_TAIL);

   // legal rows per column, bit i set means aaa == i is defined
   always_comb begin
      logic [7:0] row_mask;
      unique case (bbb)
         3'd0:    row_mask = 8'b1110_1111;
         3'd1:    row_mask = 8'b1111_0010;
         3'd2:    row_mask = 8'b1111_1111;
         3'd3:    row_mask = 8'b1111_1110;
         3'd4:    row_mask = 8'b1111_1111;
         3'd5:    row_mask = 8'b0011_0000;
         3'd6:    row_mask = 8'b1111_1111;
         default: row_mask = 8'b0010_0000;
      endcase
      slot_ok = row_mask[aaa];
   end

   always_comb begin
      dec    = '0;
      dec.op = aaa;
      if (is_branch) begin
         dec.grp   = GRP_BRANCH;
         dec.mode  = AM_REL;
         dec.legal = 1'b1;
         dec.brc   = opc[7:6];
         dec.brv   = opc[5];
      end else begin
         dec.grp   = GRP_CTRL;
         dec.legal = slot_ok;
         unique case (bbb)
            3'd0: begin
               if (aaa == 3'd1)     dec.mode = AM_ABS;
               else if (!aaa[2])    dec.mode = AM_IMP;
               else                 dec.mode = AM_IMM;
            end
            3'd1:    dec.mode = AM_ZP;
            3'd3:    dec.mode = (aaa == 3'd3) ? AM_IND : AM_ABS;
            3'd5:    dec.mode = AM_ZPX;
            3'd7:    dec.mode = AM_ABX;
            default: dec.mode = AM_IMP;
         endcase
      end
   end
endmodule

// File: rtl/opdec_bitext.sv
`timescale 1ns/1ps
module opdec_bitext
   import opdec_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);
   localparam logic [3:0] TAIL_SETCLR = 4'b0111;
   localparam logic [3:0] TAIL_TESTBR = 4'b1111;

   logic is_setclr;
   logic is_testbr;

   assign is_setclr = (opc[3:0] == TAIL_SETCLR);
   assign is_testbr = (opc[3:0] == TAIL_TESTBR);

   always_comb begin
      dec       = '0;
      dec.grp   = GRP_EXT;
      dec.op    = opc[7:5];
      dec.legal = 1'b0;
      dec.nopf  = 1'b0;
      dec.bset  = is_setclr;
      dec.bbr   = is_testbr;
      if (is_setclr || is_testbr) begin
         dec.bidx = opc[6:4];
         dec.bpol = opc[7];
      end
      if (is_setclr)      dec.mode = AM_ZP;
      else if (is_testbr) dec.mode = AM_ZPREL;
      else                dec.mode = AM_IMP;
   end
endmodule

// File: rtl/opfield_decoder.sv
`timescale 1ns/1ps
module opfield_decoder
   import opdec_pkg::*;
#(
   parameter int OPC_W   = 8,
   parameter int REG_OUT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output logic [2:0]       grp_o,
   output logic [2:0]       op_o,
   output logic [3:0]       mode_o,
   output logic             legal_o,
   output logic             nop_fetch_o,
   output logic [1:0]       br_cond_o,
   output logic             br_want_o,
   output logic             bit_op_o,
   output logic             bit_br_o,
   output logic [2:0]       bit_idx_o,
   output logic             bit_pol_o
);
   localparam int CC_W  = 2;
   localparam int BBB_W = 3;
   localparam int AAA_W = OPC_W - CC_W - BBB_W;
   localparam int N_GRP = 1 << CC_W;

   if (OPC_W != 8) begin : g_bad_width
      $error("opfield_decoder: OPC_W must be 8");
   end
   if (AAA_W != 3) begin : g_bad_split
      $error("opfield_decoder: field split must leave 3 operation bits");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("opfield_decoder: REG_OUT must be 0 or 1");
   end

   dec_t             grp_dec [N_GRP];
   dec_t             dec_c;
   dec_t             dec_q;
   logic [CC_W-1:0]  cc;

   assign cc = opcode[CC_W-1:0];

   opdec_ctrl   #(.OPC_W(OPC_W)) u_ctrl   (.opc(opcode), .dec(grp_dec[0]));
   opdec_alu    #(.OPC_W(OPC_W)) u_alu    (.opc(opcode), .dec(grp_dec[1]));
   opdec_rmw    #(.OPC_W(OPC_W)) u_rmw    (.opc(opcode), .dec(grp_dec[2]));
   opdec_bitext #(.OPC_W(OPC_W)) u_bitext (.opc(opcode), .dec(grp_dec[3]));

   assign dec_c = grp_dec[cc];

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dec_q <= '0;
         else        dec_q <= dec_c;
      end
   end else begin : g_comb
      assign dec_q = dec_c;
   end

   assign grp_o       = dec_q.grp;
   assign op_o        = dec_q.op;
   assign mode_o      = dec_q.mode;
   assign legal_o     = dec_q.legal;
   assign nop_fetch_o = dec_q.nopf;
   assign br_cond_o   = dec_q.brc;
   assign br_want_o   = dec_q.brv;
   assign bit_op_o    = dec_q.bset;
   assign bit_br_o    = dec_q.bbr;
   assign bit_idx_o   = dec_q.bidx;
   assign bit_pol_o   = dec_q.bpol;
endmodule

// File: rtl/opdec_chk.sv
`timescale 1ns/1ps
module opdec_chk
   import opdec_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] opcode,
   input logic [2:0] grp_o,
   input logic [3:0] mode_o,
   input logic       legal_o,
   input logic       nop_fetch_o,
   input logic [1:0] br_cond_o,
   input logic       br_want_o,
   input logic       bit_op_o,
   input logic       bit_br_o,
   input logic [2:0] bit_idx_o,
   input logic       bit_pol_o
);
   logic [7:0] ref_opc;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   if (REG_OUT == 1) begin : g_lat
      logic [7:0] opc_q;
      always_ff @(posedge clk) opc_q <= opcode;
      assign ref_opc = opc_q;

      assert_reset_clear_R1: assert property (@(posedge clk)
         !rst_n |=> (grp_o == 3'd0 && !legal_o && !nop_fetch_o && !bit_op_o && !bit_br_o));
   end else begin : g_nolat
      assign ref_opc = opcode;
   end

   assert_cc3_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_opc[1:0] == 2'b11) |-> (!legal_o && !nop_fetch_o && grp_o == GRP_EXT));

   assert_nop_has_operand_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      nop_fetch_o |-> (!legal_o && mode_o != AM_IMP && mode_o != AM_ACC));

   assert_no_store_aby_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_opc == 8'h9E) |-> (!legal_o && nop_fetch_o && mode_o == AM_ABY));

   assert_branch_fields_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_opc[4:0] == 5'b10000) |->
         (grp_o == GRP_BRANCH && legal_o && br_cond_o == ref_opc[7:6] && br_want_o == ref_opc[5]));

   assert_setclr_fields_R11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_opc[3:0] == 4'b0111) |->
         (bit_op_o && bit_idx_o == ref_opc[6:4] && bit_pol_o == ref_opc[7]));

   assert_testbr_fields_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ref_opc[3:0] == 4'b1111) |->
         (bit_br_o && bit_idx_o == ref_opc[6:4] && bit_pol_o == ref_opc[7]));

   assert_forms_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $onehot0({bit_op_o, bit_br_o, grp_o == GRP_BRANCH}));
endmodule

bind opfield_decoder opdec_chk #(.REG_OUT(REG_OUT)) u_opdec_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .opcode      (opcode),
   .grp_o       (grp_o),
   .mode_o      (mode_o),
   .legal_o     (legal_o),
   .nop_fetch_o (nop_fetch_o),
   .br_cond_o   (br_cond_o),
   .br_want_o   (br_want_o),
   .bit_op_o    (bit_op_o),
   .bit_br_o    (bit_br_o),
   .bit_idx_o   (bit_idx_o),
   .bit_pol_o   (bit_pol_o)
);

// File: tb/test_opfield_decoder.sv
`timescale 1ns/1ps
module test_opfield_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opcode = 8'hA9;
   logic [2:0] grp_o, op_o, bit_idx_o;
   logic [3:0] mode_o;
   logic [1:0] br_cond_o;
   logic       legal_o, nop_fetch_o, br_want_o, bit_op_o, bit_br_o, bit_pol_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   int pending[$];

   always #2.5 clk = ~clk;

   opfield_decoder #(.OPC_W(8), .REG_OUT(1)) i_opfield_decoder (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .grp_o(grp_o), .op_o(op_o), .mode_o(mode_o), .legal_o(legal_o),
      .nop_fetch_o(nop_fetch_o), .br_cond_o(br_cond_o), .br_want_o(br_want_o),
      .bit_op_o(bit_op_o), .bit_br_o(bit_br_o), .bit_idx_o(bit_idx_o),
      .bit_pol_o(bit_pol_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic bit in_list(input int o, input int lst[]);
      foreach (lst[i]) if (lst[i] == o) return 1'b1;
      return 1'b0;
   endfunction

   // expected decode, built from the requirement text
   task automatic expect_of(input int o,
      output int grp, output int op, output int mode, output int legal, output int nopf,
      output int brc, output int brv, output int bset, output int bbr, output int bidx,
      output int bpol);
      int a, b, c;
      int ctrl_ok[]  = '{'h00,'h20,'h40,'h60,'hA0,'hC0,'hE0,'h24,'h84,'hA4,'hC4,'hE4,
                         'h08,'h28,'h48,'h68,'h88,'hA8,'hC8,'hE8,'h2C,'h4C,'h6C,'h8C,
                         'hAC,'hCC,'hEC,'h94,'hB4,'h18,'h38,'h58,'h78,'h98,'hB8,'hD8,
                         'hF8,'hBC};
      int rmw_bad[]  = '{'h02,'h22,'h42,'h62,'h82,'hC2,'hE2,'h12,'h32,'h52,'h72,'h92,
                         'hB2,'hD2,'hF2,'h1A,'h3A,'h5A,'h7A,'hDA,'hFA,'h9E};
      int rmw_nopf[] = '{'h02,'h22,'h42,'h62,'h82,'hC2,'hE2,'h9E};
      a = o >> 5; b = (o >> 2) & 7; c = o & 3;
      grp = 0; op = a; mode = 0; legal = 0; nopf = 0;
      brc = 0; brv = 0; bset = 0; bbr = 0; bidx = 0; bpol = 0;
      if (c == 3) begin
         grp = 4;
         if ((o & 15) == 7)       begin bset = 1; mode = 3;  end
         else if ((o & 15) == 15) begin bbr = 1;  mode = 13; end
         if (bset || bbr) begin bidx = (o >> 4) & 7; bpol = o >> 7; end
      end else if (c == 1) begin
         grp = 1;
         case (b)
            0: mode = 9;  1: mode = 3; 2: mode = 2; 3: mode = 6;
            4: mode = 10; 5: mode = 4; 6: mode = 8; default: mode = 7;
         endcase
         legal = (o != 'h89); nopf = (o == 'h89);
      end else if (c == 2) begin
         grp = 2;
         case (b)
            0: mode = 2; 1: mode = 3; 2: mode = (a < 4) ? 1 : 0; 3: mode = 6;
            5: mode = (a == 4 || a == 5) ? 5 : 4;
            7: mode = (a == 4 || a == 5) ? 8 : 7;
            default: mode = 0;
         endcase
         legal = !in_list(o, rmw_bad); nopf = in_list(o, rmw_nopf);
      end else if ((o & 31) == 16) begin
         grp = 3; mode = 12; legal = 1; brc = o >> 6; brv = (o >> 5) & 1;
      end else begin
         case (b)
            0: mode = (a == 1) ? 6 : ((a < 4) ? 0 : 2);
            1: mode = 3;
            3: mode = (o == 'h6C) ? 11 : 6;
            5: mode = 4;
            7: mode = 7;
            default: mode = 0;
         endcase
         legal = in_list(o, ctrl_ok);
      end
   endtask

   task automatic compare_all(input int o);
      int grp, op, mode, legal, nopf, brc, brv, bset, bbr, bidx, bpol;
      string tg, tm, tl, tb;
      expect_of(o, grp, op, mode, legal, nopf, brc, brv, bset, bbr, bidx, bpol);
      tg = "R3"; tm = "R10"; tl = "R10";
      tb = ((o & 15) == 7) ? "R11" : "R12";
      case (o & 3)
         3: begin tg = "R2"; tl = "R2"; tm = ((o & 15) == 7) ? "R11" : (((o & 15) == 15) ? "R12" : "R2"); end
         1: begin tm = "R4"; tl = (o == 'h89) ? "R5" : "R4"; end
         2: begin tm = (o == 'h9E) ? "R8" : "R6"; tl = (o == 'h9E) ? "R8" : "R7"; end
         default: if ((o & 31) == 16) begin tg = "R9"; tm = "R9"; tl = "R9"; end
      endcase
      chk(tg, $sformatf("grp op=%02h", o), grp_o, grp);
      chk(tg, $sformatf("op op=%02h", o), op_o, op);
      chk(tm, $sformatf("mode op=%02h", o), mode_o, mode);
      chk(tl, $sformatf("legal op=%02h", o), legal_o, legal);
      chk(tl, $sformatf("nop_fetch op=%02h", o), nop_fetch_o, nopf);
      chk("R9", $sformatf("br_cond op=%02h", o), br_cond_o, brc);
      chk("R9", $sformatf("br_want op=%02h", o), br_want_o, brv);
      chk("R11", $sformatf("bit_op op=%02h", o), bit_op_o, bset);
      chk("R12", $sformatf("bit_br op=%02h", o), bit_br_o, bbr);
      chk(tb, $sformatf("bit_idx op=%02h", o), bit_idx_o, bidx);
      chk(tb, $sformatf("bit_pol op=%02h", o), bit_pol_o, bpol);
   endtask

   task automatic check_zero(input string what);
      chk("R1", {what, " grp"}, grp_o, 0);
      chk("R1", {what, " mode"}, mode_o, 0);
      chk("R1", {what, " legal"}, legal_o, 0);
      chk("R1", {what, " bit forms"}, {bit_op_o, bit_br_o, bit_idx_o}, 0);
      chk("R1", {what, " branch"}, {br_cond_o, br_want_o}, 0);
   endtask

   // drive one opcode per cycle, compare the one driven a cycle earlier
   task automatic sweep(input int mul, input int add);
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (pending.size() > 0) compare_all(pending.pop_front());
         opcode = 8'((i * mul + add) & 255);
         pending.push_back(int'(opcode));
      end
      @(negedge clk);
      compare_all(pending.pop_front());
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_zero("in reset");
      rst_n = 1'b1;
      sweep(1, 0);
      sweep(167, 45);
      // R1: latency of one clock
      @(negedge clk); opcode = 8'hA9;
      @(negedge clk); opcode = 8'h03;
      #1;
      chk("R1", "before edge grp", grp_o, 1);
      @(negedge clk);
      chk("R1", "after edge grp", grp_o, 4);
      // R1: reset in mid-run clears the outputs at once
      opcode = 8'h10;
      @(negedge clk); rst_n = 1'b0;
      #1;
      check_zero("mid-run reset");
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
      end
   end
endmodule